// File: doc/BRIEF.md
# Region-Based Memory Access Guard

This block decides, for every memory access, whether the access is allowed and which memory attributes apply to it. It keeps eight numbered regions. Each region has its own enable, base address, power-of-two size, permission code, execute-never bit and attribute byte. Instruction fetches and data accesses are checked against the same regions.

The access check is purely combinational. The address, the write flag, the fetch flag and the privilege flag go in, and the fault flag, hit flag, winning region number and attributes come out in the same cycle. Because the block adds no cycle, it has no valid/ready handshake; the caller qualifies the outputs with its own access strobe. Regions are written through a plain register write port, and a write takes effect at the next rising clock edge. A separate global enable turns checking on and off.

When more than one enabled region contains the address, the region with the highest number decides. When no region contains it, a background rule applies: the default attributes are returned and only privileged accesses are allowed.

Top module: `mem_guard`

## Requirements
- R1: After reset every region is disabled and checking is off: acc_fault=0, acc_hit=0, acc_region=0, acc_attr=DEF_ATTR.
- R2: While checking is off (last glb_en written as 0), every access gives acc_fault=0, acc_hit=0, acc_region=0, acc_attr=DEF_ATTR, whatever the regions hold.
- R3: A region contains an address when the address bits at and above bit cfg_size equal the same bits of the stored base. The base bits below the size are ignored. cfg_size is log2 of the byte count, from 5 (32 bytes) to 32 (4 GB). Values below 5 act as 5 and values above 32 act as 32.
- R4: Disabled regions never match. Among enabled regions that match, the highest-numbered one wins, and its number is shown on acc_region with acc_hit=1.
- R5: cfg_perm encodes 0 = no access, 1 = privileged read/write only, 2 = privileged read/write plus unprivileged read, 3 = full access. Any access the code does not permit sets acc_fault.
- R6: An instruction fetch (acc_fetch=1) that hits a region whose execute-never bit is set faults. Apart from that rule, a fetch is checked as a read.
- R7: When checking is on and no region matches: acc_hit=0, acc_region=0, acc_attr=DEF_ATTR, and acc_fault=1 exactly when acc_priv=0.
- R8: Fetches and data accesses are matched against the same region set and produce the same region and attributes.
- R9: A region write (cfg_we=1) changes the check result only from the next rising clock edge. Before that edge the old setting applies.
- R10: On a hit, acc_attr equals the attribute byte of the winning region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one region's settings |
| cfg_idx | input | 3 | Region number being written |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 6 | log2 of region byte count |
| cfg_perm | input | 2 | Permission code |
| cfg_xn | input | 1 | Execute-never bit |
| cfg_attr | input | 8 | Attribute byte |
| glb_we | input | 1 | Write the global enable |
| glb_en | input | 1 | Global enable value |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = instruction fetch |
| acc_priv | input | 1 | 1 = privileged access |
| acc_fault | output | 1 | Access is not allowed |
| acc_hit | output | 1 | Some enabled region matched |
| acc_region | output | 3 | Winning region number |
| acc_attr | output | 8 | Attributes that apply |

## Verification
A vector table drives reads, writes and fetches at both privilege levels. It covers plain hits, which separate the permission codes, and overlapping regions, which tell priority apart from first-match order. It also covers addresses on the last byte inside a region and the first byte past it, which expose off-by-one masks, plus a disabled region lying over live addresses. Directed tests cover the rest. One samples the outputs before and after the clock edge that takes a write, to check the timing. Others use a 4 GB region with an unaligned base, a size code below the minimum, the background rule at each privilege level, and the global disable.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int NREG     = 8;
  localparam int IDX_W    = $clog2(NREG);
  localparam int AW       = 32;
  localparam int SZ_W     = 6;
  localparam int ATTR_W   = 8;
  localparam int MIN_LOG2 = 5;

  typedef enum logic [1:0] {
    PERM_NONE     = 2'd0,
    PERM_PRIV     = 2'd1,
    PERM_PRIV_URO = 2'd2,
    PERM_FULL     = 2'd3
  } perm_e;

  typedef struct packed {
    logic              en;
    logic [AW-1:0]     base;
    logic [SZ_W-1:0]   size;
    perm_e             perm;
    logic              xn;
    logic [ATTR_W-1:0] attr;
  } region_t;
endpackage

// File: rtl/mg_region_file.sv
module mg_region_file
  import mg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  region_t              cfg_wdata,
  input  logic                 glb_we,
  input  logic                 glb_en,
  output region_t [NREG-1:0]   rg_q,
  output logic                 glb_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rg_q[i] <= '0;
      else if (cfg_we && cfg_idx == IDX_W'(i))
        rg_q[i] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= 1'b0;
    else if (glb_we) glb_q <= glb_en;
  end
endmodule

// File: rtl/mg_region_match.sv
module mg_region_match
  import mg_pkg::*;
(
  input  region_t        rg,
  input  logic [AW-1:0]  addr,
  output logic           hit
);
  logic [SZ_W-1:0] eff_size;
  logic [AW:0]     low_ones;
  logic [AW-1:0]   keep_mask;

  always_comb begin
    if (rg.size < SZ_W'(MIN_LOG2))  eff_size = SZ_W'(MIN_LOG2);
    else if (rg.size > SZ_W'(AW))   eff_size = SZ_W'(AW);
    else                            eff_size = rg.size;
    low_ones  = ({{AW{1'b0}}, 1'b1} << eff_size) - 1'b1;
    keep_mask = ~low_ones[AW-1:0];
    hit       = rg.en && (((addr ^ rg.base) & keep_mask) == '0);
  end
endmodule

// File: rtl/mg_pick.sv
module mg_pick
  import mg_pkg::*;
(
  input  logic [NREG-1:0]  hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = 0; i < NREG; i++)
      if (hits[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/mg_perm_check.sv
module mg_perm_check
  import mg_pkg::*;
(
  input  perm_e perm,
  input  logic  xn,
  input  logic  priv,
  input  logic  write,
  input  logic  fetch,
  output logic  fault
);
  logic perm_bad;
  always_comb begin
    unique case (perm)
      PERM_NONE:     perm_bad = 1'b1;
      PERM_PRIV:     perm_bad = !priv;
      PERM_PRIV_URO: perm_bad = !priv && write;
      default:       perm_bad = 1'b0;
    endcase
    fault = perm_bad || (fetch && xn);
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter logic [ATTR_W-1:0] DEF_ATTR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [AW-1:0]     cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic [1:0]        cfg_perm,
  input  logic              cfg_xn,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic              glb_we,
  input  logic              glb_en,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_priv,
  output logic              acc_fault,
  output logic              acc_hit,
  output logic [IDX_W-1:0]  acc_region,
  output logic [ATTR_W-1:0] acc_attr
);
  region_t              cfg_wdata;
  region_t [NREG-1:0]   rg_q;
  logic                 glb_q;
  logic [NREG-1:0]      hits;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  region_t              win_rg;
  logic                 perm_fault;

  always_comb begin
    cfg_wdata.en   = cfg_en;
    cfg_wdata.base = cfg_base;
    cfg_wdata.size = cfg_size;
    cfg_wdata.perm = perm_e'(cfg_perm);
    cfg_wdata.xn   = cfg_xn;
    cfg_wdata.attr = cfg_attr;
  end

  mg_region_file u_file (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .glb_we(glb_we), .glb_en(glb_en),
    .rg_q(rg_q), .glb_q(glb_q)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_match
    mg_region_match u_match (.rg(rg_q[i]), .addr(acc_addr), .hit(hits[i]));
  end

  mg_pick u_pick (.hits(hits), .any(any_hit), .idx(win_idx));

  assign win_rg = rg_q[win_idx];

  mg_perm_check u_perm (
    .perm(win_rg.perm), .xn(win_rg.xn), .priv(acc_priv),
    .write(acc_write), .fetch(acc_fetch), .fault(perm_fault)
  );

  always_comb begin
    acc_fault  = 1'b0;
    acc_hit    = 1'b0;
    acc_region = '0;
    acc_attr   = DEF_ATTR;
    if (glb_q) begin
      if (any_hit) begin
        acc_fault  = perm_fault;
        acc_hit    = 1'b1;
        acc_region = win_idx;
        acc_attr   = win_rg.attr;
      end else begin
        acc_fault  = !acc_priv;
      end
    end
  end
endmodule

// File: rtl/mg_checker.sv
module mg_checker
  import mg_pkg::*;
#(
  parameter logic [ATTR_W-1:0] DEF_ATTR = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [IDX_W-1:0]   cfg_idx,
  input logic [AW-1:0]      cfg_base,
  input logic               acc_write,
  input logic               acc_fetch,
  input logic               acc_priv,
  input logic               acc_fault,
  input logic               acc_hit,
  input logic [IDX_W-1:0]   acc_region,
  input logic [ATTR_W-1:0]  acc_attr,
  input region_t [NREG-1:0] rg_q,
  input logic               glb_q
);
  // R2
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q |-> (!acc_fault && !acc_hit && acc_attr == DEF_ATTR));

  // R7
  background_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_q && !acc_hit) |-> (acc_fault == !acc_priv && acc_attr == DEF_ATTR));

  // R4
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> rg_q[acc_region].en);

  // R6
  exec_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_q && acc_hit && acc_fetch && rg_q[acc_region].xn) |-> acc_fault);

  // R5
  unpriv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_q && acc_hit && !acc_priv && acc_write &&
     rg_q[acc_region].perm != PERM_FULL) |-> acc_fault);

  // R10
  attr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> acc_attr == rg_q[acc_region].attr);

  // R9
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> rg_q[$past(cfg_idx)].base == $past(cfg_base));
endmodule

bind mem_guard mg_checker #(.DEF_ATTR(DEF_ATTR)) u_mg_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_base(cfg_base), .acc_write(acc_write), .acc_fetch(acc_fetch),
  .acc_priv(acc_priv), .acc_fault(acc_fault), .acc_hit(acc_hit),
  .acc_region(acc_region), .acc_attr(acc_attr), .rg_q(rg_q), .glb_q(glb_q)
);

// File: tb/test_mem_guard.sv
module test_mem_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0, cfg_xn = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [5:0]  cfg_size = '0;
  logic [1:0]  cfg_perm = '0;
  logic [7:0]  cfg_attr = '0;
  logic        glb_we = 1'b0, glb_en = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_priv = 1'b0;
  logic        acc_fault, acc_hit;
  logic [2:0]  acc_region;
  logic [7:0]  acc_attr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mem_guard i_mem_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_perm(cfg_perm), .cfg_xn(cfg_xn), .cfg_attr(cfg_attr),
    .glb_we(glb_we), .glb_en(glb_en), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_priv(acc_priv),
    .acc_fault(acc_fault), .acc_hit(acc_hit), .acc_region(acc_region),
    .acc_attr(acc_attr)
  );

  // {priv, write, fetch, addr, fault, hit, region, attr}
  localparam int NV = 16;
  localparam logic [47:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,32'h0000_0100, 1'b0,1'b1,3'd0,8'h10},
    {1'b0,1'b1,1'b0,32'h0000_0100, 1'b0,1'b1,3'd0,8'h10},
    {1'b1,1'b1,1'b0,32'h0000_1234, 1'b0,1'b1,3'd1,8'h11},
    {1'b0,1'b0,1'b0,32'h0000_1234, 1'b1,1'b1,3'd1,8'h11},
    {1'b0,1'b0,1'b0,32'h2000_0010, 1'b0,1'b1,3'd2,8'h22},
    {1'b0,1'b1,1'b0,32'h2000_0010, 1'b1,1'b1,3'd2,8'h22},
    {1'b1,1'b0,1'b1,32'h2000_0010, 1'b1,1'b1,3'd2,8'h22},
    {1'b0,1'b1,1'b0,32'h2000_0500, 1'b0,1'b1,3'd5,8'h55},
    {1'b1,1'b0,1'b1,32'h2000_07FC, 1'b0,1'b1,3'd5,8'h55},
    {1'b0,1'b1,1'b0,32'h2000_0800, 1'b1,1'b1,3'd2,8'h22},
    {1'b1,1'b0,1'b0,32'h4000_001F, 1'b1,1'b1,3'd7,8'h77},
    {1'b1,1'b0,1'b0,32'h4000_0020, 1'b0,1'b0,3'd0,8'h00},
    {1'b0,1'b0,1'b0,32'h4000_0020, 1'b1,1'b0,3'd0,8'h00},
    {1'b1,1'b0,1'b0,32'h8000_0010, 1'b0,1'b0,3'd0,8'h00},
    {1'b1,1'b1,1'b0,32'h0000_FFFF, 1'b0,1'b1,3'd0,8'h10},
    {1'b1,1'b0,1'b0,32'h0001_0000, 1'b0,1'b0,3'd0,8'h00}
  };

  task automatic expect_out(input string req, input logic f, input logic h,
                            input logic [2:0] r, input logic [7:0] a);
    checks++;
    if (acc_fault !== f || acc_hit !== h || acc_region !== r || acc_attr !== a) begin
      errors++;
      $display("FAIL %s addr=%h: got fault=%b hit=%b region=%0d attr=%h, expected fault=%b hit=%b region=%0d attr=%h",
               req, acc_addr, acc_fault, acc_hit, acc_region, acc_attr, f, h, r, a);
    end
  endtask

  task automatic access(input logic p, input logic w, input logic f, input logic [31:0] a);
    acc_priv = p; acc_write = w; acc_fetch = f; acc_addr = a;
    #1;
  endtask

  task automatic wr_region(input logic [2:0] idx, input logic en, input logic [31:0] base,
                           input logic [5:0] sz, input logic [1:0] perm, input logic xn,
                           input logic [7:0] attr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_base = base;
    cfg_size = sz; cfg_perm = perm; cfg_xn = xn; cfg_attr = attr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_glb(input logic en);
    @(negedge clk);
    glb_we = 1'b1; glb_en = en;
    @(negedge clk);
    glb_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    access(1'b0, 1'b1, 1'b0, 32'h4000_0000);
    expect_out("R1", 1'b0, 1'b0, 3'd0, 8'h00);

    wr_region(3'd0, 1'b1, 32'h0000_0000, 6'd16, 2'd3, 1'b0, 8'h10);
    wr_region(3'd1, 1'b1, 32'h0000_1000, 6'd12, 2'd1, 1'b0, 8'h11);
    wr_region(3'd2, 1'b1, 32'h2000_0000, 6'd20, 2'd2, 1'b1, 8'h22);
    wr_region(3'd3, 1'b0, 32'h8000_0000, 6'd12, 2'd3, 1'b0, 8'h33);
    wr_region(3'd5, 1'b1, 32'h2000_0400, 6'd10, 2'd3, 1'b0, 8'h55);
    wr_region(3'd7, 1'b1, 32'h4000_0000, 6'd5,  2'd0, 1'b0, 8'h77);

    // R2: regions programmed, checking still off
    @(negedge clk);
    access(1'b0, 1'b1, 1'b0, 32'h4000_0000);
    expect_out("R2", 1'b0, 1'b0, 3'd0, 8'h00);

    wr_glb(1'b1);
    // R3 R4 R5 R6 R7 R8 R10: table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      access(VEC[i][47], VEC[i][46], VEC[i][45], VEC[i][44:13]);
      expect_out($sformatf("R3/R4/R5/R6/R7/R8/R10 vec%0d", i),
                 VEC[i][12], VEC[i][11], VEC[i][10:8], VEC[i][7:0]);
    end

    // R9: write visible only after the next rising edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_en = 1'b1; cfg_base = 32'h1234_5678;
    cfg_size = 6'd32; cfg_perm = 2'd3; cfg_xn = 1'b0; cfg_attr = 8'h66;
    access(1'b0, 1'b0, 1'b0, 32'h0001_0000);
    expect_out("R9 before edge", 1'b1, 1'b0, 3'd0, 8'h00);
    @(posedge clk);
    #1;
    expect_out("R9 after edge", 1'b0, 1'b1, 3'd6, 8'h66);
    @(negedge clk);
    cfg_we = 1'b0;

    // R3: 4 GB region, unaligned base bits ignored; R4: region 7 still beats 6
    access(1'b1, 1'b0, 1'b0, 32'h4000_0000);
    expect_out("R4 r7 over r6", 1'b1, 1'b1, 3'd7, 8'h77);
    access(1'b0, 1'b1, 1'b0, 32'h2000_0500);
    expect_out("R4 r6 over r5", 1'b0, 1'b1, 3'd6, 8'h66);

    // R3: size code below minimum acts as 32 bytes
    wr_region(3'd6, 1'b1, 32'h5000_0000, 6'd2, 2'd3, 1'b0, 8'h66);
    access(1'b0, 1'b0, 1'b0, 32'h5000_001F);
    expect_out("R3 min size in", 1'b0, 1'b1, 3'd6, 8'h66);
    access(1'b1, 1'b0, 1'b0, 32'h5000_0020);
    expect_out("R3 min size out", 1'b0, 1'b0, 3'd0, 8'h00);

    // R8: fetch and data read see the same region
    access(1'b1, 1'b0, 1'b1, 32'h0000_1234);
    expect_out("R8 fetch", 1'b0, 1'b1, 3'd1, 8'h11);

    // R2: checking turned off again
    wr_glb(1'b0);
    access(1'b0, 1'b1, 1'b1, 32'h4000_0000);
    expect_out("R2 off again", 1'b0, 1'b0, 3'd0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule